// File: doc/BRIEF.md
# Port Change Wake-up Interrupt Unit

This unit watches a multi-bit input port and compares each synchronised sample with a reference value. Software loads the reference by reading the port. Once the change enable is set, any difference between the port and the reference raises a sticky pending flag. That flag serves two purposes. It wakes the core while the core is asleep, and it raises a maskable interrupt request.

The global interrupt-enable input decides what happens once the core is awake. When it is set, the unit emits a one-cycle vector-take pulse, and the core branches to a fixed vector address (0x3FE by default). When it is clear, the unit emits a one-cycle resume pulse on the first awake cycle, and the core continues with its next instruction. To use a pin change as a wake-up source, software disables the watchdog before sleeping, reads the port, and then sets the change enable.

All pins are plain level controls. No stream carries data through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pcw_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pending`, `wake`, `irq`, `vec_take` and `resume_next` are all 0, and the stored reference is all zeros.
- R2: A cycle with `port_rd` high loads the reference with the synchronised port value. If the pins then hold steady, no change is reported.
- R3: A pin value applied before clock edge k passes through two synchroniser flops. If it differs from the reference and `chg_en` is 1, `pending` reads 1 after edge k+2.
- R4: While `chg_en` is 0, a difference between the port and the reference never sets `pending`.
- R5: `pending` stays set until a cycle with `pend_clr` high, even if the pins return to the reference value. A change detected in the same cycle as `pend_clr` keeps `pending` set, because setting wins over clearing.
- R6: A port read while `pending` is 1 updates the reference but leaves `pending` at 1.
- R7: `wake` is 1 exactly while `sleeping` and `pending` are both 1.
- R8: `irq` is 1 exactly while `pending` and `gie` are both 1.
- R9: `vec_take` pulses for one cycle when `pending` and `gie` are 1 and `sleeping` is 0. It pulses once per pending episode, and a new episode starts at a `pend_clr` cycle. `vec_addr` is constant at 0x3FE.
- R10: `resume_next` pulses for one cycle on the first cycle with `sleeping` at 0 after a cycle with `sleeping` at 1, provided `pending` is 1 and `gie` is 0.
- R11: No change is detected in a cycle in which `port_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 8 | Asynchronous port pins |
| port_rd | input | 1 | Port read strobe; loads the reference |
| chg_en | input | 1 | Change detection enable |
| gie | input | 1 | Global interrupt enable |
| sleeping | input | 1 | Core is in sleep |
| pend_clr | input | 1 | Software clear of the pending flag |
| wake | output | 1 | Wake request to the core |
| irq | output | 1 | Interrupt request level |
| vec_take | output | 1 | One-cycle pulse: branch to the vector |
| vec_addr | output | 10 | Interrupt vector address |
| resume_next | output | 1 | One-cycle pulse: continue with the next instruction |
| pending | output | 1 | Sticky change flag |

## Verification
The hardest case to reach is the collision between a software clear and a change that is still present. In that cycle the set must win, and the vector logic must re-arm so that a second vector pulse follows. The bench reaches it by holding `pend_clr` high while the pins stay away from the reference. The other hard case is the sleep-exit ordering. Here `sleeping` falls while the flag is pending, under each value of `gie`, which decides whether the resume pulse or the vector pulse appears on the first awake cycle. A cycle-accurate behavioural model is compared with every output on every clock. Long random phases add port reads and clears that overlap with changes in transit through the synchroniser.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef struct packed {
    logic wake;
    logic irq;
    logic vec_take;
    logic resume_next;
  } pcw_evt_t;
endpackage

// File: rtl/pcw_sync.sv
module pcw_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcw_ref_cmp.sv
module pcw_ref_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         load,
  input  logic         en,
  output logic         hit
);
  logic [W-1:0] ref_q;
  logic [W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    ref_q <= '0;
    else if (load) ref_q <= pins;

  assign diff = pins ^ ref_q;
  // A read resynchronises the reference, so detection is masked that cycle.
  assign hit  = en & ~load & (|diff);

  assert_ref_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ref_q == $past(pins)));
  assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (ref_q == $past(ref_q)));
endmodule

// File: rtl/pcw_pend.sv
module pcw_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pending <= 1'b0;
    else        pending <= set | (pending & ~clr);

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pending);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> pending);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pending);
endmodule

// File: rtl/pcw_dispatch.sv
module pcw_dispatch
  import pcw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pending,
  input  logic     gie,
  input  logic     sleeping,
  input  logic     clr,
  output pcw_evt_t evt
);
  logic taken_q;
  logic sleep_q;
  logic awake_now;

  assign awake_now       = ~sleeping;
  assign evt.wake        = sleeping & pending;
  assign evt.irq         = pending & gie;
  assign evt.vec_take    = pending & gie & awake_now & ~taken_q;
  assign evt.resume_next = pending & ~gie & awake_now & sleep_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      taken_q <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      taken_q <= ~clr & pending & (taken_q | evt.vec_take);
      sleep_q <= sleeping;
    end

  assert_vec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.vec_take && !clr) |=> !evt.vec_take);
  assert_resume_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt.resume_next |=> !evt.resume_next);
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.vec_take && evt.resume_next));
  assert_wake_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt.wake |-> !(evt.vec_take || evt.resume_next));
endmodule

// File: rtl/pcw_unit.sv
module pcw_unit
  import pcw_pkg::*;
#(
  parameter int                PORT_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter int                VEC_W       = 10,
  parameter logic [VEC_W-1:0]  VEC_ADDR    = 10'h3FE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              port_rd,
  input  logic              chg_en,
  input  logic              gie,
  input  logic              sleeping,
  input  logic              pend_clr,
  output logic              wake,
  output logic              irq,
  output logic              vec_take,
  output logic [VEC_W-1:0]  vec_addr,
  output logic              resume_next,
  output logic              pending
);
  logic [PORT_W-1:0] pin_sync;
  logic              hit;
  pcw_evt_t          evt;

  pcw_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  pcw_ref_cmp #(.W(PORT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pins(pin_sync), .load(port_rd),
    .en(chg_en), .hit(hit)
  );

  pcw_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set(hit), .clr(pend_clr), .pending(pending)
  );

  pcw_dispatch u_disp (
    .clk(clk), .rst_n(rst_n), .pending(pending), .gie(gie),
    .sleeping(sleeping), .clr(pend_clr), .evt(evt)
  );

  assign wake        = evt.wake;
  assign irq         = evt.irq;
  assign vec_take    = evt.vec_take;
  assign resume_next = evt.resume_next;
  assign vec_addr    = VEC_ADDR;

  assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_en && !pending) |=> !pending);
  assert_read_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && !pending) |=> !pending);
  assert_read_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && pending && !pend_clr) |=> pending);
endmodule

// File: tb/test_pcw_unit.sv
`timescale 1ns/1ps
module test_pcw_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic       port_rd = 1'b0, chg_en = 1'b0, gie = 1'b0, sleeping = 1'b0, pend_clr = 1'b0;
  logic       wake, irq, vec_take, resume_next, pending;
  logic [9:0] vec_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcw_unit i_pcw_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .port_rd(port_rd),
    .chg_en(chg_en), .gie(gie), .sleeping(sleeping), .pend_clr(pend_clr),
    .wake(wake), .irq(irq), .vec_take(vec_take), .vec_addr(vec_addr),
    .resume_next(resume_next), .pending(pending)
  );

  // Behavioural reference model: queue of samples in flight, reference word, flags.
  logic [7:0] mq[$];
  logic [7:0] m_ref;
  bit m_pend, m_taken, m_sq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq = '{8'h00, 8'h00};
      m_ref = 8'h00; m_pend = 0; m_taken = 0; m_sq = 0;
    end else begin
      bit hit, vt;
      hit = chg_en && !port_rd && (mq[0] != m_ref);
      vt  = m_pend && gie && !sleeping && !m_taken;
      if (port_rd) m_ref = mq[0];
      m_taken = !pend_clr && m_pend && (m_taken || vt);
      m_pend  = hit || (m_pend && !pend_clr);
      m_sq    = sleeping;
      void'(mq.pop_front());
      mq.push_back(pin_in);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output with the model on every falling edge.
  always @(negedge clk) if (rst_n && !done) begin
    bit e_wake, e_irq, e_vt, e_res;
    e_wake = sleeping && m_pend;
    e_irq  = m_pend && gie;
    e_vt   = m_pend && gie && !sleeping && !m_taken;
    e_res  = m_sq && !sleeping && m_pend && !gie;
    check(pending == m_pend, "R3 pending", pending, m_pend);
    check(wake == e_wake, "R7 wake", wake, e_wake);
    check(irq == e_irq, "R8 irq", irq, e_irq);
    check(vec_take == e_vt, "R9 vec_take", vec_take, e_vt);
    check(resume_next == e_res, "R10 resume_next", resume_next, e_res);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd_port();
    port_rd = 1; cyc(1); port_rd = 0;
  endtask

  task automatic clr_pend();
    pend_clr = 1; cyc(1); pend_clr = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int vt_cnt;
    pin_in = 8'h3C;
    cyc(3);
    @(negedge clk);
    check({pending, wake, irq, vec_take, resume_next} == 5'b0, "R1 reset outputs",
          {pending, wake, irq, vec_take, resume_next}, 0);
    cyc(0); rst_n = 1; cyc(1);
    check(pending == 0, "R1 first cycle", pending, 0);
    // R4: difference to reset reference 00 but disabled
    cyc(5);
    check(pending == 0, "R4 disabled no set", pending, 0);
    // R2: read then enable, steady pins
    rd_port(); chg_en = 1; cyc(6);
    check(pending == 0, "R2 reference loaded", pending, 0);
    // R3: change timing
    pin_in = 8'hC3; cyc(2);
    check(pending == 0, "R3 not before edge k+2", pending, 0);
    cyc(1);
    check(pending == 1, "R3 set after edge k+2", pending, 1);
    check(irq == 0, "R8 gie clear", irq, 0);
    // R5: pins return, still pending
    pin_in = 8'h3C; cyc(5);
    check(pending == 1, "R5 sticky", pending, 1);
    // R6: read while pending
    rd_port(); cyc(2);
    check(pending == 1, "R6 read keeps pending", pending, 1);
    clr_pend(); cyc(1);
    check(pending == 0, "R5 cleared", pending, 0);
    // R9: run mode with gie, one vector per episode
    gie = 1; pin_in = 8'h3D; vt_cnt = 0;
    repeat (10) begin @(negedge clk); if (vec_take) vt_cnt++; end
    check(vt_cnt == 1, "R9 one vector", vt_cnt, 1);
    check(vec_addr == 10'h3FE, "R9 vector address", vec_addr, 10'h3FE);
    // R5 collision: clear with change still present -> stays set, re-vectors
    cyc(0); pend_clr = 1; cyc(1); pend_clr = 0;
    check(pending == 1, "R5 set wins", pending, 1);
    @(negedge clk);
    check(vec_take == 1, "R9 re-armed", vec_take, 1);
    cyc(0); rd_port(); clr_pend(); cyc(2);
    check(pending == 0, "R5 clear after read", pending, 0);
    // R10: sleep wake with gie=0
    gie = 0; sleeping = 1; pin_in = 8'h00; cyc(4);
    check(wake == 1, "R7 wake in sleep", wake, 1);
    sleeping = 0;
    @(negedge clk);
    check(resume_next == 1 && vec_take == 0, "R10 resume", resume_next, 1);
    cyc(1); rd_port(); clr_pend(); cyc(2);
    // sleep wake with gie=1 -> vector on first awake cycle
    gie = 1; sleeping = 1; pin_in = 8'hFF; cyc(4);
    check(vec_take == 0, "R9 no vector asleep", vec_take, 0);
    sleeping = 0;
    @(negedge clk);
    check(vec_take == 1 && resume_next == 0, "R9 vector after wake", vec_take, 1);
    cyc(1); rd_port(); clr_pend(); cyc(2);
    // R11: port read every cycle while pins move
    port_rd = 1;
    for (int i = 0; i < 6; i++) begin pin_in = 8'(i * 37); cyc(1); end
    cyc(3); port_rd = 0; cyc(3);
    check(pending == 0, "R11 read masks detection", pending, 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) pin_in = 8'($urandom);
      port_rd  = ($urandom_range(0, 9) == 0);
      pend_clr = ($urandom_range(0, 11) == 0);
      if (r > 95) chg_en = ~chg_en;
      if (r == 50 || r == 51) gie = ~gie;
      if (r > 90 && r < 94) sleeping = ~sleeping;
      cyc(1);
    end
    port_rd = 0; pend_clr = 0; cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule